// File: doc/BRIEF.md
# Video Line Mute Timing Generator

This block follows the raster of an on-screen-display video signal and produces a blanking window at the start of every horizontal line. It keeps a 9-bit count of the current line. The count is cleared when the vertical sync pulse ends and advances on each horizontal sync. A CPU can read the count.

At each line start the block raises a mute output and a matching horizontal-sync status flag. The window length comes from a 3-bit length setting, written through a one-cycle register strobe, and is timed with an external 1 µs tick from the crystal timebase. In double-rate line mode each unit of the setting lasts one tick. In single-rate line mode each unit lasts two ticks. A setting of zero makes the window follow the horizontal sync pulse itself. The length and the line mode are captured at the start of each line, so changing them part-way through a line does not alter the window that is already running.

Top module: `vmute_top`

## Requirements
- R1: After reset the line count reads 0, mute and flag are low, and the stored length setting is 0. A line started before any write therefore lasts exactly as long as horizontal sync is high.
- R2: One clock edge after the vertical sync input falls from 1 to 0, the line count is 0. This takes priority over a horizontal sync rise in the same cycle.
- R3: A rise of horizontal sync (0 to 1) adds one to the line count one clock edge later. With no sync edge, the count holds.
- R4: The line count stops at 511 and does not wrap when further horizontal syncs arrive.
- R5: Mute and flag are high one clock edge after a horizontal sync rise. A rise while a window is running restarts it with the full length, and a tick in the same cycle as the rise is not counted.
- R6: With dbl_rate_i = 1 and length L (1 to 7) captured at line start, mute falls at the clock edge that samples the L-th tick.
- R7: With dbl_rate_i = 0 and length L (1 to 7), mute falls at the clock edge that samples the 2·L-th tick.
- R8: With length 0, mute stays high while horizontal sync is high, falls one clock edge after sync falls, and ignores ticks.
- R9: A length written with cfg_we_i = 1 (value on cfg_len_i[2:0]), or a change of dbl_rate_i, during a running window does not change that window. The new value applies from the next line start.
- R10: hsy_flag_o equals mute_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Vertical sync, active high |
| hsync_i | input | 1 | Horizontal sync, active high |
| tick_us_i | input | 1 | One-cycle 1 µs timebase tick |
| dbl_rate_i | input | 1 | 1 = double-rate line (1 tick per unit), 0 = single-rate (2 ticks per unit) |
| cfg_we_i | input | 1 | Write strobe for the length setting |
| cfg_len_i | input | 3 | Mute length setting to write |
| line_cnt_o | output | 9 | Current scan line count |
| mute_o | output | 1 | Line-start mute window |
| hsy_flag_o | output | 1 | Horizontal-sync status flag |

## Verification
A table walks every kind of timed window: lengths 1, 5 and 7 in double-rate mode and 1, 3 and 7 in single-rate mode. Counting ticks until mute drops tells apart a missing scale factor, an off-by-one terminal count and a wrong mode select. Directed patterns give a length of zero with a wide sync pulse (sync following against timed counting), a restart part-way through a window, a tick coinciding with a line start, and writes made mid-line (capture at line start against live use). Runs of more than 511 lines, and a vertical sync ending together with a horizontal sync rise, separate saturation from wrap-around and show the priority of the clear.

// File: rtl/vmute_pkg.sv
package vmute_pkg;

   // window controller states
   typedef enum logic [1:0] {
      MW_IDLE   = 2'd0,
      MW_TIMED  = 2'd1,
      MW_FOLLOW = 2'd2
   } mw_state_e;

   localparam int unsigned VM_LINE_W_DEF = 9;
   localparam int unsigned VM_LEN_W_DEF  = 3;

endpackage

// File: rtl/vmute_edge.sv
// Edge detector for a sync input, with polarity chosen at elaboration.
module vmute_edge #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   logic lvl;
   logic prev_q;

   if (ACTIVE_HIGH) begin : g_pos
      assign lvl = sig_i;
   end else begin : g_neg
      assign lvl = ~sig_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign lvl_o  = lvl;
   assign rise_o = lvl & ~prev_q;
   assign fall_o = ~lvl & prev_q;

endmodule

// File: rtl/vmute_linecnt.sv
// Saturating scan line counter; clear has priority over increment.
module vmute_linecnt #(
   parameter int unsigned LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [LINE_W-1:0] cnt_o
);

   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

   logic [LINE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/vmute_window.sv
// Line-start window: timed by ticks, or following sync when length is 0.
module vmute_window
   import vmute_pkg::*;
#(
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             hs_lvl_i,
   input  logic             dbl_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             mute_o,
   output logic [LEN_W-1:0] act_len_o
);

   localparam int unsigned CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   mw_state_e        state_q;
   logic [CNT_W-1:0] rem_q;
   logic [LEN_W-1:0] act_len_q;
   logic [CNT_W-1:0] load_val;

   // double-rate: one tick per unit, single-rate: two ticks per unit
   assign load_val = dbl_i ? CNT_W'(len_i) : {len_i, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= MW_IDLE;
         rem_q     <= '0;
         act_len_q <= '0;
      end else if (start_i) begin
         act_len_q <= len_i;
         if (len_i == '0) begin
            state_q <= MW_FOLLOW;
            rem_q   <= '0;
         end else begin
            state_q <= MW_TIMED;
            rem_q   <= load_val;
         end
      end else begin
         case (state_q)
            MW_TIMED: begin
               if (tick_i) begin
                  if (rem_q == CNT_ONE) state_q <= MW_IDLE;
                  rem_q <= rem_q - 1'b1;
               end
            end
            MW_FOLLOW: begin
               if (!hs_lvl_i) state_q <= MW_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign mute_o    = (state_q != MW_IDLE);
   assign act_len_o = act_len_q;

endmodule

// File: rtl/vmute_top.sv
module vmute_top
   import vmute_pkg::*;
#(
   parameter int unsigned LINE_W      = VM_LINE_W_DEF,
   parameter int unsigned LEN_W       = VM_LEN_W_DEF,
   parameter bit          SYNC_ACT_HI = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_i,
   input  logic              hsync_i,
   input  logic              tick_us_i,
   input  logic              dbl_rate_i,
   input  logic              cfg_we_i,
   input  logic [LEN_W-1:0]  cfg_len_i,
   output logic [LINE_W-1:0] line_cnt_o,
   output logic              mute_o,
   output logic              hsy_flag_o
);

   if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line_w
      $error("vmute_top: LINE_W out of range");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len_w
      $error("vmute_top: LEN_W out of range");
   end

   logic             hs_lvl, hs_rise, hs_fall;
   logic             vs_lvl, vs_rise, vs_fall;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] act_len;
   logic             win_mute;

   vmute_edge #(.ACTIVE_HIGH(SYNC_ACT_HI)) u_hs_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (hsync_i),
      .lvl_o  (hs_lvl),
      .rise_o (hs_rise),
      .fall_o (hs_fall)
   );

   vmute_edge #(.ACTIVE_HIGH(SYNC_ACT_HI)) u_vs_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (vsync_i),
      .lvl_o  (vs_lvl),
      .rise_o (vs_rise),
      .fall_o (vs_fall)
   );

   // length setting register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        len_q <= '0;
      else if (cfg_we_i) len_q <= cfg_len_i;
   end

   vmute_linecnt #(.LINE_W(LINE_W)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (vs_fall),
      .inc_i (hs_rise),
      .cnt_o (line_cnt_o)
   );

   vmute_window #(.LEN_W(LEN_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (hs_rise),
      .tick_i    (tick_us_i),
      .hs_lvl_i  (hs_lvl),
      .dbl_i     (dbl_rate_i),
      .len_i     (len_q),
      .mute_o    (win_mute),
      .act_len_o (act_len)
   );

   assign mute_o     = win_mute;
   assign hsy_flag_o = win_mute;

endmodule

// File: rtl/vmute_chk.sv
module vmute_chk #(
   parameter int unsigned LINE_W = 9,
   parameter int unsigned LEN_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hs_rise,
   input logic              vs_fall,
   input logic              hs_fall,
   input logic              vs_rise,
   input logic              vs_lvl,
   input logic              tick,
   input logic              mute,
   input logic              flag,
   input logic [LINE_W-1:0] line_cnt,
   input logic [LEN_W-1:0]  act_len
);

   localparam logic [LINE_W-1:0] L_MAX = {LINE_W{1'b1}};

   // R2
   a_r2_vs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      vs_fall |=> (line_cnt == '0));

   // R3
   a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_rise && !vs_fall && line_cnt != L_MAX)
      |=> (line_cnt == LINE_W'($past(line_cnt) + 1'b1)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_rise && !vs_fall) |=> $stable(line_cnt));

   // R4
   a_r4_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cnt == L_MAX && !vs_fall) |=> (line_cnt == L_MAX));

   // R5
   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      hs_rise |=> (mute && flag));

   a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!mute && !hs_rise) |=> !mute);

   // R6
   a_r6_tick_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (mute && !hs_rise && !tick && act_len != '0) |=> mute);

endmodule

bind vmute_top vmute_chk #(.LINE_W(LINE_W), .LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hs_rise  (hs_rise),
   .vs_fall  (vs_fall),
   .hs_fall  (hs_fall),
   .vs_rise  (vs_rise),
   .vs_lvl   (vs_lvl),
   .tick     (tick_us_i),
   .mute     (mute_o),
   .flag     (hsy_flag_o),
   .line_cnt (line_cnt_o),
   .act_len  (act_len)
);

// File: tb/vmute_top_tb.sv
module vmute_top_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vsync = 1'b0, hsync = 1'b0, tick = 1'b0, dbl = 1'b1;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_len = 3'd0;
   logic [8:0] line_cnt;
   logic       mute, flag;

   int n_chk = 0;
   int n_fail = 0;
   int exp_line = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vmute_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .vsync_i    (vsync),
      .hsync_i    (hsync),
      .tick_us_i  (tick),
      .dbl_rate_i (dbl),
      .cfg_we_i   (cfg_we),
      .cfg_len_i  (cfg_len),
      .line_cnt_o (line_cnt),
      .mute_o     (mute),
      .hsy_flag_o (flag)
   );

   // {dbl, len[2:0], expected ticks[3:0]}
   localparam logic [7:0] VEC [6] = '{
      {1'b1, 3'd1, 4'd1},
      {1'b1, 3'd5, 4'd5},
      {1'b1, 3'd7, 4'd7},
      {1'b0, 3'd1, 4'd2},
      {1'b0, 3'd3, 4'd6},
      {1'b0, 3'd7, 4'd14}
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_mute(input string req, input int exp);
      check(mute == exp[0], req, int'(mute), exp);
      check(flag == mute, "R10", int'(flag), int'(mute));
   endtask

   task automatic chk_line(input string req);
      check(int'(line_cnt) == exp_line, req, int'(line_cnt), exp_line);
   endtask

   task automatic write_len(input int v);
      cfg_len = v[2:0];
      cfg_we  = 1'b1;
      step();
      cfg_we  = 1'b0;
   endtask

   task automatic line_start();
      hsync = 1'b1;
      step();
      if (exp_line < 511) exp_line++;
      chk_mute("R5", 1);
      hsync = 1'b0;
      step();
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      step();
      tick = 1'b0;
   endtask

   task automatic count_ticks(output int n);
      n = 0;
      while (mute && n < 40) begin
         pulse_tick();
         n++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int n;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk_line("R1");
      chk_mute("R1", 0);
      // R1 length defaults to 0: window follows a 3-cycle sync
      hsync = 1'b1;
      n = 0;
      for (int i = 0; i < 3; i++) begin
         step();
         if (mute) n++;
      end
      exp_line++;
      hsync = 1'b0;
      step();
      check(n == 3 && !mute, "R1", n, 3);
      chk_line("R3");

      // table walk: R6 / R7
      foreach (VEC[i]) begin
         dbl = VEC[i][7];
         write_len(int'(VEC[i][6:4]));
         line_start();
         count_ticks(n);
         check(n == int'(VEC[i][3:0]), VEC[i][7] ? "R6" : "R7", n, int'(VEC[i][3:0]));
         chk_mute("R6", 0);
         chk_line("R3");
      end

      // R3 hold: ticks without sync leave count unchanged
      for (int i = 0; i < 4; i++) pulse_tick();
      chk_line("R3");

      // R8 zero length, wide sync with ticks applied
      write_len(0);
      hsync = 1'b1;
      n = 0;
      for (int i = 0; i < 6; i++) begin
         tick = (i % 2 == 1);
         step();
         if (mute) n++;
      end
      tick = 1'b0;
      exp_line++;
      hsync = 1'b0;
      step();
      check(n == 6, "R8", n, 6);
      chk_mute("R8", 0);

      // R9 mid-line length and mode change
      dbl = 1'b1;
      write_len(4);
      line_start();
      write_len(1);
      dbl = 1'b0;
      count_ticks(n);
      check(n == 4, "R9", n, 4);
      dbl = 1'b1;
      line_start();
      count_ticks(n);
      check(n == 1, "R9", n, 1);

      // R5 restart mid-window
      write_len(3);
      line_start();
      pulse_tick();
      pulse_tick();
      line_start();
      count_ticks(n);
      check(n == 3, "R5", n, 3);

      // R5 tick coinciding with line start is not counted
      hsync = 1'b1;
      tick  = 1'b1;
      step();
      exp_line++;
      tick  = 1'b0;
      hsync = 1'b0;
      step();
      count_ticks(n);
      check(n == 3, "R5", n, 3);

      // R2 vertical sync clear
      vsync = 1'b1;
      step();
      vsync = 1'b0;
      step();
      exp_line = 0;
      chk_line("R2");

      // R4 saturation
      write_len(0);
      for (int i = 0; i < 515; i++) line_start();
      check(line_cnt == 9'd511, "R4", int'(line_cnt), 511);

      // R2 priority over simultaneous hsync rise
      vsync = 1'b1;
      step();
      vsync = 1'b0;
      hsync = 1'b1;
      step();
      exp_line = 0;
      chk_line("R2");
      hsync = 1'b0;
      step();
      line_start();
      chk_line("R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule